// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers five interrupt request lines for a small 8-bit processor core and decides which one, if any, the core services at its next instruction boundary. One line is non-maskable. Three lines are maskable and carry fixed vectors. The fifth line is maskable but has no vector, so when it wins the core must run an external acknowledge cycle instead. A global enable flag gates every maskable line. A per-line mask register gates the three vectored lines as well.

The lines use different trigger styles. The two lower vectored lines are sampled as plain levels. The top vectored line has a rising-edge latch that keeps the request pending. The non-maskable line needs a rising edge that is still high when the core samples. The core pulses `sample` once per instruction. One cycle later the block presents either a 16-bit service address with `vec_valid`, or a pulse on `ack_req`, or nothing. Accepting any maskable request clears the enable flag, so the service routine must set it again.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it, `vec_valid` and `ack_req` are 0, the enable flag is 0, all three mask bits are 1 and the edge latch is clear. A line that is high while reset is applied does not count as a rising edge.
- R2: The strobe `ie_set` sets the enable flag and `ie_clr` clears it. If both strobes are asserted in the same cycle, the flag is cleared.
- R3: The fixed priority, from highest to lowest, is: non-maskable (address 0024h), `vreq[2]` (003Ch), `vreq[1]` (0034h), `vreq[0]` (002Ch), then `ext_req`.
- R4: The non-maskable line ignores the enable flag and the masks. A rising edge must still be high at the sample to be taken. Each rise is taken at most once.
- R5: A rising edge on `vreq[2]`, including one in the sampling cycle itself, sets a pending latch. The request is then serviced even if the line has since dropped. A line that stays high produces no second request.
- R6: `vreq[1]` and `vreq[0]` are seen only if they are high in the sampling cycle.
- R7: A pulse on `mask_wr` loads `mask_wdata[2:0]` as the masks for `vreq[2:0]`, where 1 means masked. Bit `mask_wdata[3]` clears the edge latch, and this clear wins over a rise in the same cycle. A masked pending edge stays latched.
- R8: `ext_req` is gated only by the enable flag. When it wins, `ack_req` pulses and `vec_valid` stays 0.
- R9: Accepting any maskable request clears the enable flag, and this clear wins over a coincident `ie_set`. Accepting the non-maskable line leaves the flag unchanged.
- R10: Results appear in the cycle after the sampling edge and last one cycle. `vec_valid` and `ack_req` are never both high. Nothing is taken without `sample`, and `vec_addr` is 0 when `vec_valid` is low.
- R11: `status` reads as follows: bits [1:0] are the raw `vreq[1:0]`, bit [2] is the edge latch, bits [5:3] are the masks and bit [6] is the enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request line |
| vreq | input | 3 | Vectored maskable request lines; bit 2 is edge triggered |
| ext_req | input | 1 | Non-vectored maskable request line |
| ie_set | input | 1 | Enable-flag set strobe |
| ie_clr | input | 1 | Enable-flag clear strobe |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 4 | [2:0] mask bits, [3] edge-latch clear |
| sample | input | 1 | Instruction-boundary sampling strobe |
| vec_valid | output | 1 | Vectored request accepted |
| vec_addr | output | 16 | Service address when `vec_valid` is high |
| ack_req | output | 1 | External acknowledge cycle requested |
| status | output | 7 | Pending and configuration read port |

## Verification
The hardest cases to reach are the coincidences. These include a mask-write clear that lands in the same cycle as a rising edge on `vreq[2]`. They also include a maskable acceptance that lands in the same cycle as `ie_set`, and a non-maskable rise that drops before the sample or is held across several samples. Directed steps set up each of these coincidences exactly. A long seeded random run then toggles the lines, the strobes and the mask writes at different rates, so that edges, masks and samples overlap in many combinations. A cycle-level reference model in the bench predicts every output.

// File: rtl/irq_pkg.sv
// Package: shared constants for the interrupt priority controller.
// Assumes: exactly one edge-triggered vectored input, the highest one.
package irq_pkg;
    // number of vectored maskable inputs
    localparam int NV = 3;
    // mask write word: NV mask bits plus one edge-latch clear bit
    localparam int MW = NV + 1;
    // status word: NV-1 raw levels, edge latch, NV masks, enable flag
    localparam int SW = 2 * NV + 1;
endpackage

// File: rtl/irq_cond.sv
// Module: irq_cond
// Conditions the raw request lines into "live" requests for the arbiter.
// The non-maskable line is qualified by a rising edge AND the current level.
// The top vectored line is edge latched. The lower vectored lines pass as levels.
// Assumes the inputs are already synchronous to clk.
module irq_cond #(
    parameter int NV = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_i,
    input  logic [NV-1:0] vreq_i,
    input  logic          pend_clr_i,
    input  logic          take_nmi_i,
    input  logic          take_edge_i,
    output logic          nmi_live_o,
    output logic [NV-1:0] vlive_o,
    output logic          edge_pend_o
);
    logic nmi_prev, nmi_pend, nmi_rise;
    logic e_prev, e_pend, e_rise, e_live;

    // rise detectors; a rise in this cycle counts at once
    always_comb begin
        nmi_rise   = nmi_i & ~nmi_prev;
        nmi_live_o = nmi_i & (nmi_pend | nmi_rise);
        e_rise     = vreq_i[NV-1] & ~e_prev;
        e_live     = e_pend | e_rise;
    end

    // lower vectored inputs are plain levels
    generate
        for (genvar g = 0; g < NV - 1; g++) begin : g_lvl
            assign vlive_o[g] = vreq_i[g];
        end
    endgenerate
    assign vlive_o[NV-1] = e_live;
    assign edge_pend_o   = e_pend;

    // history and pending latches; prev resets high so held lines are not edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev <= 1'b1;
            e_prev   <= 1'b1;
            nmi_pend <= 1'b0;
            e_pend   <= 1'b0;
        end else begin
            nmi_prev <= nmi_i;
            e_prev   <= vreq_i[NV-1];
            nmi_pend <= (!nmi_i || take_nmi_i) ? 1'b0 : (nmi_pend | nmi_rise);
            e_pend   <= (pend_clr_i || take_edge_i) ? 1'b0 : e_live;
        end
    end

    // R4
    nmi_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take_nmi_i) |-> !nmi_live_o);

    // R5
    edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take_edge_i) |-> !edge_pend_o);
endmodule

// File: rtl/irq_state.sv
// Module: irq_state
// Holds the global enable flag and the per-input mask register.
// An acceptance clear beats a clear strobe, which beats a set strobe.
// Masks reset to all-masked.
module irq_state #(
    parameter int NV = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ie_set_i,
    input  logic          ie_clr_i,
    input  logic          acc_mask_i,
    input  logic          mask_wr_i,
    input  logic [NV-1:0] mask_wdata_i,
    output logic          ie_o,
    output logic [NV-1:0] mask_o
);
    // enable flag with fixed strobe precedence
    always_ff @(posedge clk) begin
        if (!rst_n)             ie_o <= 1'b0;
        else if (acc_mask_i)    ie_o <= 1'b0;
        else if (ie_clr_i)      ie_o <= 1'b0;
        else if (ie_set_i)      ie_o <= 1'b1;
    end

    // mask register load
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_o <= '1;
        else if (mask_wr_i) mask_o <= mask_wdata_i;
    end

    // R9
    ie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_mask_i) |-> !ie_o);

    // R2
    ie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ie_clr_i) |-> !ie_o);
endmodule

// File: rtl/irq_arb.sv
// Module: irq_arb
// Fixed-priority selection at the sampling strobe. It registers the result:
// a vector address with a valid flag, or an acknowledge-request pulse.
// Vector addresses of the vectored inputs are evenly spaced from ADDR_V0.
module irq_arb #(
    parameter int          NV        = 3,
    parameter logic [15:0] ADDR_NMI  = 16'h0024,
    parameter logic [15:0] ADDR_V0   = 16'h002C,
    parameter logic [15:0] ADDR_STEP = 16'h0008
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_i,
    input  logic          nmi_live_i,
    input  logic [NV-1:0] vlive_i,
    input  logic          ext_i,
    input  logic          ie_i,
    input  logic [NV-1:0] mask_i,
    output logic          take_nmi_o,
    output logic [NV-1:0] take_vec_o,
    output logic          acc_mask_o,
    output logic          vec_valid_o,
    output logic [15:0]   vec_addr_o,
    output logic          ack_req_o
);
    logic        hit;
    logic        take_ext;
    logic [15:0] addr_n;

    // priority scan: non-maskable, then vectored high to low, then external
    always_comb begin
        take_nmi_o = 1'b0;
        take_vec_o = '0;
        take_ext   = 1'b0;
        hit        = 1'b0;
        addr_n     = '0;
        if (sample_i) begin
            if (nmi_live_i) begin
                take_nmi_o = 1'b1;
                addr_n     = ADDR_NMI;
            end else if (ie_i) begin
                for (int i = NV - 1; i >= 0; i--) begin
                    if (!hit && vlive_i[i] && !mask_i[i]) begin
                        hit           = 1'b1;
                        take_vec_o[i] = 1'b1;
                        addr_n        = ADDR_V0 + 16'(i) * ADDR_STEP;
                    end
                end
                if (!hit && ext_i) take_ext = 1'b1;
            end
        end
        acc_mask_o = (|take_vec_o) | take_ext;
    end

    // registered result, valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid_o <= 1'b0;
            vec_addr_o  <= '0;
            ack_req_o   <= 1'b0;
        end else begin
            vec_valid_o <= take_nmi_o | (|take_vec_o);
            vec_addr_o  <= addr_n;
            ack_req_o   <= take_ext;
        end
    end

    // R10
    one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vec_valid_o, ack_req_o}));

    // R10
    out_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o || ack_req_o) |-> $past(sample_i));

    // R8
    ack_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |-> $past(ie_i));

    // R7
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|take_vec_o) |-> (take_vec_o & mask_i) == '0);
endmodule

// File: rtl/vec_irq_ctrl.sv
// Module: vec_irq_ctrl (top)
// Five-input interrupt priority controller: conditioning, enable/mask state,
// and a registered fixed-priority arbiter. Sampled once per instruction.
module vec_irq_ctrl
    import irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_req,
    input  logic [NV-1:0] vreq,
    input  logic          ext_req,
    input  logic          ie_set,
    input  logic          ie_clr,
    input  logic          mask_wr,
    input  logic [MW-1:0] mask_wdata,
    input  logic          sample,
    output logic          vec_valid,
    output logic [15:0]   vec_addr,
    output logic          ack_req,
    output logic [SW-1:0] status
);
    logic          nmi_live, edge_pend, ie, acc_mask, take_nmi;
    logic [NV-1:0] vlive, mask, take_vec;

    irq_cond #(.NV(NV)) u_cond (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi_req), .vreq_i(vreq),
        .pend_clr_i(mask_wr & mask_wdata[NV]), .take_nmi_i(take_nmi),
        .take_edge_i(take_vec[NV-1]), .nmi_live_o(nmi_live),
        .vlive_o(vlive), .edge_pend_o(edge_pend)
    );

    irq_state #(.NV(NV)) u_state (
        .clk(clk), .rst_n(rst_n), .ie_set_i(ie_set), .ie_clr_i(ie_clr),
        .acc_mask_i(acc_mask), .mask_wr_i(mask_wr),
        .mask_wdata_i(mask_wdata[NV-1:0]), .ie_o(ie), .mask_o(mask)
    );

    irq_arb #(.NV(NV)) u_arb (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .nmi_live_i(nmi_live),
        .vlive_i(vlive), .ext_i(ext_req), .ie_i(ie), .mask_i(mask),
        .take_nmi_o(take_nmi), .take_vec_o(take_vec), .acc_mask_o(acc_mask),
        .vec_valid_o(vec_valid), .vec_addr_o(vec_addr), .ack_req_o(ack_req)
    );

    // read port: raw levels, edge latch, masks, enable flag
    assign status = {ie, mask, edge_pend, vreq[NV-2:0]};

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!vec_valid && !ack_req));

    // R10
    addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> vec_addr == 16'h0000);
endmodule

// File: tb/sim_vec_irq_ctrl.sv
// Bench: seeded random plus directed steps against a cycle reference model.
module sim_vec_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        nmi, ext, ie_set, ie_clr, mask_wr, sample;
    logic [2:0]  vreq;
    logic [3:0]  wd;
    logic        vec_valid, ack_req;
    logic [15:0] vec_addr;
    logic [6:0]  status;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    // reference model state
    logic       m_ie, m_epend, m_eprev, m_npend, m_nprev;
    logic [2:0] m_mask;

    always #10 clk = ~clk;

    vec_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi), .vreq(vreq), .ext_req(ext),
        .ie_set(ie_set), .ie_clr(ie_clr), .mask_wr(mask_wr), .mask_wdata(wd),
        .sample(sample), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .ack_req(ack_req), .status(status)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        nmi = 0; ext = 0; ie_set = 0; ie_clr = 0; mask_wr = 0; wd = 0;
        sample = 0; vreq = 0;
    endtask

    // one cycle: check status, predict outputs, advance clock, compare
    task automatic cyc(string tag);
        logic erise, elive, nrise, nlive, ev, ea;
        logic [15:0] eaddr;
        int win;
        string t;
        #1;
        chk("R11 status", status, {m_ie, m_mask, m_epend, vreq[1:0]});
        erise = vreq[2] & ~m_eprev;
        elive = m_epend | erise;
        nrise = nmi & ~m_nprev;
        nlive = nmi & (m_npend | nrise);
        win = -1;
        if (sample) begin
            if (nlive) win = 3;
            else if (m_ie) begin
                if (elive && !m_mask[2])        win = 2;
                else if (vreq[1] && !m_mask[1]) win = 1;
                else if (vreq[0] && !m_mask[0]) win = 0;
                else if (ext)                   win = 4;
            end
        end
        ev = (win >= 0 && win <= 3);
        ea = (win == 4);
        case (win)
            3: eaddr = 16'h0024;
            2: eaddr = 16'h003C;
            1: eaddr = 16'h0034;
            0: eaddr = 16'h002C;
            default: eaddr = 16'h0000;
        endcase
        if (tag != "") t = tag;
        else case (win)
            3: t = "R4"; 2: t = "R5"; 1, 0: t = "R6"; 4: t = "R8";
            default: t = "R10";
        endcase
        @(posedge clk);
        m_epend = ((mask_wr && wd[3]) || win == 2) ? 1'b0 : elive;
        m_npend = (!nmi || win == 3) ? 1'b0 : (m_npend | nrise);
        m_eprev = vreq[2];
        m_nprev = nmi;
        if (win == 0 || win == 1 || win == 2 || win == 4) m_ie = 0;
        else if (ie_clr) m_ie = 0;
        else if (ie_set) m_ie = 1;
        if (mask_wr) m_mask = wd[2:0];
        @(negedge clk);
        chk({t, " out"}, {vec_valid, ack_req, vec_addr}, {ev, ea, eaddr});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        rst_n = 0;
        nmi = 1; vreq = 3'b100;        // held high across reset
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 out", {vec_valid, ack_req, vec_addr}, 18'h0);
        chk("R1 status", status, 7'b0111000);
        rst_n = 1;
        m_ie = 0; m_mask = 3'b111; m_epend = 0; m_npend = 0;
        m_eprev = 1; m_nprev = 1;
        sample = 1;
        cyc("R1");                     // held lines are not edges
        cyc("R4");                     // nmi still high: not taken
        idle(); cyc("");
        // R2 strobes
        ie_set = 1; cyc("R2");
        ie_set = 1; ie_clr = 1; cyc("R2");
        idle(); ie_set = 1; cyc("R2");
        // R7 unmask all
        idle(); mask_wr = 1; wd = 4'b0000; cyc("R7");
        // R3 everything at once with a fresh edge
        idle(); vreq = 3'b111; ext = 1; sample = 1; cyc("R3");
        idle(); ie_set = 1; cyc("R2");
        // R3 level vs ext after edge consumed
        vreq = 3'b011; ext = 1; sample = 1; cyc("R3");
        idle(); ie_set = 1; cyc("");
        // R5 short pulse, sampled later
        vreq = 3'b100; cyc("R5");
        vreq = 3'b000; cyc("R5");
        sample = 1; cyc("R5");
        idle(); ie_set = 1; cyc("");
        // R5 line stays high: no second request
        vreq = 3'b100; sample = 1; cyc("R5");
        ie_set = 1; sample = 0; cyc("");
        ie_set = 0; sample = 1; cyc("R5");
        // R6 level dropped before sample
        idle(); vreq = 3'b010; cyc("R6");
        vreq = 0; sample = 1; cyc("R6");
        // R8 ext only
        idle(); ext = 1; sample = 1; cyc("R8");
        idle(); ext = 1; sample = 1; cyc("R8");   // ie now clear
        // R9 accept coincident with set strobe
        idle(); ie_set = 1; cyc("");
        vreq = 3'b001; ie_set = 1; sample = 1; cyc("R9");
        idle(); cyc("R9");
        // R4 nmi with ie clear and all masked
        mask_wr = 1; wd = 4'b0111; cyc("R7");
        idle(); nmi = 1; sample = 1; cyc("R4");
        cyc("R4");
        nmi = 0; sample = 0; cyc("");
        nmi = 1; cyc("R4");
        nmi = 0; sample = 1; cyc("R4");           // dropped before sample
        // R7 masked pending retained, then clear beats coincident rise
        idle(); ie_set = 1; vreq = 3'b100; sample = 1; cyc("R7");
        idle(); mask_wr = 1; wd = 4'b0000; cyc("R7");
        ie_set = 1; mask_wr = 0; sample = 1; cyc("R7");
        idle(); ie_set = 1; cyc("");
        vreq = 3'b100; mask_wr = 1; wd = 4'b1000; cyc("R7");
        idle(); sample = 1; cyc("R7");
        // R10 no sample, nothing taken
        idle(); nmi = 1; vreq = 3'b111; ext = 1; ie_set = 1; cyc("R10");
        ie_set = 0; cyc("R10");
        // random phase
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(7) == 0) nmi = ~nmi;
            vreq    = 3'($urandom);
            ext     = 1'($urandom);
            ie_set  = ($urandom_range(9) < 3);
            ie_clr  = ($urandom_range(19) == 0);
            mask_wr = ($urandom_range(15) == 0);
            wd      = 4'($urandom);
            sample  = ($urandom_range(4) < 2);
            cyc("");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule